// File: doc/BRIEF.md
# Phase Detector Score Accumulator

This block rates one clock-phase setting by watching a phase detector. After a start pulse it accepts a fixed number of 32-bit status words, N of them. Each word carries two 4-bit detector codes. Every code is sorted into one of three classes: it lowers the score, it raises the score, or it has no effect. The score is held with an offset of 2N, so it is never negative.

Alongside the score, the block keeps two tallies of the "early" patterns. One counts code 0x3, which means clock 1 is early. The other counts code 0xC, which means clock 0 is early. A control loop outside the block reads the score and both tallies. It uses them to decide which way to move a delay line.

When the last sample of a run has been taken, the block raises done for a single cycle. The results then stay put until the next start.

Top module: `pd_score_acc`

## Requirements
- R1: After reset, done_o is 0, score_o equals 2N and both tallies are 0.
- R2: A start_i pulse while idle begins a run. From the next cycle score_o equals 2N and both tallies read 0.
- R3: Each accepted word holds two codes: the lower code in bits 27:24 and the upper code in bits 31:28. Both codes are applied in the same cycle. The other bits have no effect.
- R4: Codes 0x3 and 0xC each lower score_o by one.
- R5: Codes 0x1, 0x4 and 0x5 each raise score_o by one. Every other code leaves score_o unchanged.
- R6: Code 0x3 adds one to early1_cnt_o. Code 0xC adds one to early0_cnt_o.
- R7: A run accepts exactly N words, one per cycle in which sample_valid_i is high. done_o is high for exactly the one cycle after the clock edge that takes the Nth word.
- R8: After a run ends, score_o and both tallies hold their values until the next start.
- R9: A word presented while the block is idle is ignored. This includes a word presented in the same cycle as start_i.
- R10: A start_i pulse during a run is ignored, and the run continues.
- R11: score_o always stays within 0 to 4N. A run of all-penalty codes ends at 0, and a run of all-reward codes ends at 4N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a run when idle |
| sample_valid_i | input | 1 | A status word is present on sample_i |
| sample_i | input | 32 | Detector status word |
| done_o | output | 1 | One-cycle pulse after the last word of a run |
| score_o | output | $clog2(4N+1) | Offset score, 2N at the start of a run |
| early1_cnt_o | output | $clog2(2N+1) | Count of code 0x3 (clock 1 early) |
| early0_cnt_o | output | $clog2(2N+1) | Count of code 0xC (clock 0 early) |

## Verification
Two overlaps are provoked on purpose.

The first is a start pulse in the same cycle as a valid word. The bench checks that the run begins with a clean 2N score and zero tallies, and that the word in that cycle is not counted.

The second is a start pulse raised in the middle of a run. The bench checks that the running score continues undisturbed, and that done still arrives after the Nth accepted word and not later.

// File: rtl/pd_score_acc.sv
module pd_score_acc #(
  parameter int N = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          sample_valid_i,
  input  logic [31:0]                   sample_i,
  output logic                          done_o,
  output logic [$clog2(4*N+1)-1:0]      score_o,
  output logic [$clog2(2*N+1)-1:0]      early1_cnt_o,
  output logic [$clog2(2*N+1)-1:0]      early0_cnt_o
);
  localparam int SW = $clog2(4*N+1);
  localparam int CW = $clog2(2*N+1);
  localparam int KW = $clog2(N+1);
  localparam logic [SW-1:0] BASE = SW'(2*N);

  logic          busy;
  logic [KW-1:0] taken;
  logic          done_q;
  logic [SW-1:0] score_q;
  logic [CW-1:0] c1_q, c0_q;

  wire [3:0] lo = sample_i[27:24];
  wire [3:0] hi = sample_i[31:28];

  function automatic logic is_pen(input logic [3:0] c);
    return (c == 4'h3) || (c == 4'hC);
  endfunction

  function automatic logic is_rew(input logic [3:0] c);
    return (c == 4'h1) || (c == 4'h4) || (c == 4'h5);
  endfunction

  wire launch = start_i & ~busy;
  wire accept = sample_valid_i & busy;

  wire [1:0] n_rew = {1'b0, is_rew(lo)} + {1'b0, is_rew(hi)};
  wire [1:0] n_pen = {1'b0, is_pen(lo)} + {1'b0, is_pen(hi)};
  wire [1:0] n_e1  = {1'b0, lo == 4'h3} + {1'b0, hi == 4'h3};
  wire [1:0] n_e0  = {1'b0, lo == 4'hC} + {1'b0, hi == 4'hC};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      taken   <= '0;
      done_q  <= 1'b0;
      score_q <= BASE;
      c1_q    <= '0;
      c0_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        busy    <= 1'b1;
        taken   <= '0;
        score_q <= BASE;
        c1_q    <= '0;
        c0_q    <= '0;
      end else if (accept) begin
        score_q <= score_q + SW'(n_rew) - SW'(n_pen);
        c1_q    <= c1_q + CW'(n_e1);
        c0_q    <= c0_q + CW'(n_e0);
        taken   <= taken + 1'b1;
        if (taken == KW'(N-1)) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o       = done_q;
  assign score_o      = score_q;
  assign early1_cnt_o = c1_q;
  assign early0_cnt_o = c0_q;

  a_r11_score_range: assert property (@(posedge clk) disable iff (!rst_n)
    score_q <= SW'(4*N));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  a_r2_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (score_q == BASE) && (c1_q == '0) && (c0_q == '0));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(score_q) && $stable(c1_q) && $stable(c0_q));
  a_r6_tally_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (int'(c1_q) + int'(c0_q)) <= (int'($past(c1_q)) + int'($past(c0_q)) + 2));
endmodule

// File: tb/tb_pd_score_acc.sv
module tb_pd_score_acc;
  localparam int N  = 20;
  localparam int SW = $clog2(4*N+1);
  localparam int CW = $clog2(2*N+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sample_valid_i = 1'b0;
  logic [31:0] sample_i = '0;
  logic done_o;
  logic [SW-1:0] score_o;
  logic [CW-1:0] early1_cnt_o, early0_cnt_o;

  always #2.5 clk = ~clk;

  pd_score_acc #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .sample_valid_i(sample_valid_i), .sample_i(sample_i),
    .done_o(done_o), .score_o(score_o),
    .early1_cnt_o(early1_cnt_o), .early0_cnt_o(early0_cnt_o));

  int runs = 0;
  int fails = 0;

  localparam logic [31:0] TW [0:19] = '{
    32'h33000000, 32'hCC00FFFF, 32'h3C000000, 32'h15000000, 32'h41000000,
    32'h54ABCDEF, 32'h00000000, 32'h26000000, 32'h13000000, 32'hC4000000,
    32'h7F123456, 32'h8E000000, 32'h9B000000, 32'hDA000000, 32'h05000000,
    32'h30000000, 32'h0C000000, 32'h11000000, 32'h03FFFFFF, 32'hF2000000};
  localparam int TD [0:19] = '{-2,-2,-2, 2, 2, 2, 0, 0, 0, 0, 0, 0, 0, 0, 1,-1,-1, 2,-1, 0};
  localparam int T1 [0:19] = '{ 2, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0};
  localparam int T0 [0:19] = '{ 0, 2, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0};

  task automatic check(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [31:0] w);
    sample_valid_i = 1'b1;
    sample_i = w;
    @(negedge clk);
    sample_valid_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int es, e1, e0;
    repeat (3) @(negedge clk);
    check("R1 done", done_o, 0);
    check("R1 score", score_o, 2*N);
    check("R1 early1", early1_cnt_o, 0);
    check("R1 early0", early0_cnt_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(32'h11111111);
    check("R9 idle word score", score_o, 2*N);

    pulse_start();
    check("R2 start score", score_o, 2*N);
    es = 2*N; e1 = 0; e0 = 0;
    for (int i = 0; i < N; i++) begin
      check("R7 no early done", done_o, 0);
      send(TW[i]);
      es += TD[i]; e1 += T1[i]; e0 += T0[i];
      check("R3 R4 R5 score", score_o, es);
      check("R6 early1", early1_cnt_o, e1);
      check("R6 early0", early0_cnt_o, e0);
    end
    check("R7 done pulse", done_o, 1);
    @(negedge clk);
    check("R7 done one cycle", done_o, 0);
    send(32'h33333333);
    check("R8 score hold", score_o, es);
    check("R8 early1 hold", early1_cnt_o, e1);
    check("R8 early0 hold", early0_cnt_o, e0);

    start_i = 1'b1;
    sample_valid_i = 1'b1;
    sample_i = 32'h11000000;
    @(negedge clk);
    start_i = 1'b0;
    sample_valid_i = 1'b0;
    check("R9 start-cycle word ignored", score_o, 2*N);
    check("R2 early1 cleared", early1_cnt_o, 0);
    check("R2 early0 cleared", early0_cnt_o, 0);
    for (int i = 0; i < N; i++) begin
      send(32'h33000000);
      if (i == 4) begin
        pulse_start();
        check("R10 start mid-run ignored", score_o, 2*N - 10);
      end
    end
    check("R11 floor", score_o, 0);
    check("R6 all-3 tally", early1_cnt_o, 2*N);
    check("R10 done on Nth", done_o, 1);

    pulse_start();
    for (int i = 0; i < N; i++) begin
      sample_valid_i = 1'b0;
      if (i % 3 == 1) @(negedge clk);
      send(32'h45000000);
    end
    check("R11 ceiling", score_o, 4*N);
    check("R7 done after gaps", done_o, 1);
    check("R6 no tally", early0_cnt_o, 0);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset restores", score_o, 2*N);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule